// File: doc/BRIEF.md
# Parallel Flash Command Controller with Write Protection

This block behaves like the command front end of a parallel NOR flash device. It runs on a system clock and samples the device strobes on that clock: chip-enable, write-enable, output-enable, a reset/power-down pin and a write-protect pin, all active low. A bus write takes effect on the rising edge of write-enable while chip-enable is low. The written byte is decoded as a command. Program and erase each need two bus writes. The target address, and for a program the data, are held internally for the whole operation.

A small register array stands in for the flash cells. A program can only clear bits. An erase returns a whole block to all ones. A simulated operation keeps the block busy for a set number of clocks. The two lowest blocks are parameter blocks that can be locked: while write-protect is low they refuse program and erase, and the refusal is reported in the status register. The data bus is driven only during a read. The value on it comes from the array, from two identifier bytes, or from the status register, depending on the current read mode.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: `dq_oe` is 1 only while `rp_n` is high and both `ce_n` and `oe_n` are low. Whenever `dq_oe` is 0, `dq_out` reads all zeros.
- R2: After system reset the read mode is array read, every array word reads 0xFF, and the status register reads 0x80.
- R3: Command bytes set the read mode: 0xFF gives array read, 0x90 gives identifier read and 0x70 gives status read. In identifier mode, address bit 0 = 0 returns the maker code (default 0xA5) and 1 returns the device code (default 0x3C). Unlisted command bytes are ignored.
- R4: A bus write is taken when `we_n` rises while `ce_n` is low. A write strobed with `ce_n` high has no effect. A program is 0x40 followed by the data write, and the addressed word becomes old AND data.
- R5: An erase is 0x20 followed by a 0xD0 confirm. It sets every word of the addressed block (BLK_WORDS words, block index = address divided by BLK_WORDS) to 0xFF and leaves other blocks unchanged.
- R6: After 0x20, any second byte other than 0xD0 sets status bits 4 and 5 and changes no array word.
- R7: Status layout: bit 7 = ready, bit 5 = erase fail, bit 4 = program fail, bit 1 = lock fail, all other bits 0. A program or erase setup switches the read mode to status. After an accepted confirming write, bit 7 reads 0 for exactly BUSY_CYC clocks. Writes while busy are ignored.
- R8: Blocks 0 and 1 are lockable. With `wp_n` low, a program to them sets bits 1 and 4 and an erase sets bits 1 and 5; the array is left unchanged and no busy period occurs. With `wp_n` high they behave as normal blocks. Blocks 2 and up are never refused.
- R9: The error bits stay set through later successful operations and are cleared only by the command 0x50.
- R10: While `rp_n` is low, any running or half-entered operation is abandoned without changing the array, writes are ignored and the error bits are cleared. When `rp_n` is released, the read mode is array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all strobes |
| rst_n | input | 1 | Synchronous active-low system reset |
| rp_n | input | 1 | Device reset / power-down pin, active low |
| wp_n | input | 1 | Write-protect pin; low locks blocks 0 and 1 |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; rising edge commits a write |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | DW | Data bus from the host (commands and program data) |
| dq_out | output | DW | Data bus towards the host |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
The bench targets the protection cases. A locked parameter block must refuse both program and erase with the right pair of status bits. An unlockable block must still be programmed while write-protect is low. A design that locked the wrong blocks, or went busy on a refusal, would show the wrong status byte or a changed word. It checks that an erase confirm other than 0xD0 sets both fail bits, that error bits survive a later good program, and that program ANDs into the old word instead of overwriting it. It also pulls the reset pin low in the middle of a program. A design that still committed the latched data, kept the error bits, or kept a stale read mode would read back 0x00 or a wrong status instead of 0xFF and 0x80.

// File: rtl/flash_cmd_pkg.sv
// Shared command codes, read modes and engine states for the flash
// command controller. Assumes command bytes occupy data bits [7:0].
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_IDENT,
        RD_STATUS
    } rd_mode_e;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_PROG_SETUP,
        EN_ERASE_SETUP,
        EN_BUSY
    } eng_state_e;

    localparam logic [7:0] OPC_READ_ARRAY    = 8'hFF;
    localparam logic [7:0] OPC_READ_IDENT    = 8'h90;
    localparam logic [7:0] OPC_READ_STATUS   = 8'h70;
    localparam logic [7:0] OPC_CLR_STATUS    = 8'h50;
    localparam logic [7:0] OPC_PROG_SETUP    = 8'h40;
    localparam logic [7:0] OPC_ERASE_SETUP   = 8'h20;
    localparam logic [7:0] OPC_ERASE_CONFIRM = 8'hD0;

    // Number of low-index blocks that write-protect can lock.
    localparam int LOCKABLE_BLKS = 2;

endpackage

// File: rtl/fcc_strobe_edge.sv
// Detects a committed bus write: a rising edge of we_n seen on clk while
// chip enable was low through the low phase and at the rising edge.
// Assumes strobes are already synchronous to clk and every low phase of
// we_n lasts at least one clock.
module fcc_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    output logic wr_evt
);

    logic we_q;
    logic ce_q;

    // Keep last sampled strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            ce_q <= 1'b1;
        end else begin
            we_q <= we_n;
            ce_q <= ce_n;
        end
    end

    // Write commits on the low-to-high transition of we_n under chip enable.
    always_comb begin
        wr_evt = !we_q && we_n && !ce_q && !ce_n;
    end

endmodule

// File: rtl/fcc_cmd_engine.sv
// Command decoder, lock check, busy timer and status bits. Latches the
// target address and data on the confirming write and pulses fire on the
// final busy clock so the array commits the operation. Assumes DW >= 8
// and BUSY_CYC >= 1.
module fcc_cmd_engine
    import flash_cmd_pkg::*;
#(
    parameter int AW       = 5,
    parameter int DW       = 8,
    parameter int WW       = 2,
    parameter int BUSY_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rp_n,
    input  logic          wp_n,
    input  logic          wr_evt,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output rd_mode_e      rd_mode,
    output logic [7:0]    status,
    output logic          fire,
    output logic          fire_erase,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data
);

    localparam int BW = AW - WW;
    localparam int CW = $clog2(BUSY_CYC) + 1;
    localparam logic [CW-1:0] BUSY_LOAD = CW'(BUSY_CYC - 1);

    eng_state_e    state;
    logic [CW-1:0] cnt;
    logic          sr_prog, sr_erase, sr_lock;
    logic          op_erase;
    logic [7:0]    cmd;
    logic [BW-1:0] tgt_blk;
    logic          blk_locked;

    // Decode the byte and target block of the current bus write.
    always_comb begin
        cmd        = dq_in[7:0];
        tgt_blk    = addr[AW-1:WW];
        blk_locked = !wp_n && (tgt_blk < BW'(LOCKABLE_BLKS));
    end

    // Command sequencing, busy timing and sticky status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= EN_IDLE;
            rd_mode  <= RD_ARRAY;
            cnt      <= '0;
            sr_prog  <= 1'b0;
            sr_erase <= 1'b0;
            sr_lock  <= 1'b0;
            op_erase <= 1'b0;
            op_addr  <= '0;
            op_data  <= '0;
        end else if (!rp_n) begin
            state    <= EN_IDLE;
            rd_mode  <= RD_ARRAY;
            cnt      <= '0;
            sr_prog  <= 1'b0;
            sr_erase <= 1'b0;
            sr_lock  <= 1'b0;
        end else begin
            case (state)
                EN_IDLE: begin
                    if (wr_evt) begin
                        case (cmd)
                            OPC_READ_ARRAY:  rd_mode <= RD_ARRAY;
                            OPC_READ_IDENT:  rd_mode <= RD_IDENT;
                            OPC_READ_STATUS: rd_mode <= RD_STATUS;
                            OPC_CLR_STATUS: begin
                                sr_prog  <= 1'b0;
                                sr_erase <= 1'b0;
                                sr_lock  <= 1'b0;
                            end
                            OPC_PROG_SETUP: begin
                                state   <= EN_PROG_SETUP;
                                rd_mode <= RD_STATUS;
                            end
                            OPC_ERASE_SETUP: begin
                                state   <= EN_ERASE_SETUP;
                                rd_mode <= RD_STATUS;
                            end
                            default: ;
                        endcase
                    end
                end
                EN_PROG_SETUP: begin
                    if (wr_evt) begin
                        op_addr  <= addr;
                        op_data  <= dq_in;
                        op_erase <= 1'b0;
                        if (blk_locked) begin
                            sr_lock <= 1'b1;
                            sr_prog <= 1'b1;
                            state   <= EN_IDLE;
                        end else begin
                            cnt   <= BUSY_LOAD;
                            state <= EN_BUSY;
                        end
                    end
                end
                EN_ERASE_SETUP: begin
                    if (wr_evt) begin
                        if (cmd == OPC_ERASE_CONFIRM) begin
                            op_addr  <= addr;
                            op_erase <= 1'b1;
                            if (blk_locked) begin
                                sr_lock  <= 1'b1;
                                sr_erase <= 1'b1;
                                state    <= EN_IDLE;
                            end else begin
                                cnt   <= BUSY_LOAD;
                                state <= EN_BUSY;
                            end
                        end else begin
                            sr_prog  <= 1'b1;
                            sr_erase <= 1'b1;
                            state    <= EN_IDLE;
                        end
                    end
                end
                EN_BUSY: begin
                    if (cnt == '0) begin
                        state <= EN_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= EN_IDLE;
            endcase
        end
    end

    // Commit strobe to the array and assembled status byte.
    always_comb begin
        fire       = (state == EN_BUSY) && (cnt == '0) && rp_n;
        fire_erase = op_erase;
        status     = {state != EN_BUSY, 1'b0, sr_erase, sr_prog,
                      2'b00, sr_lock, 1'b0};
    end

    // R7: the busy timer steps down by one each clock until it expires.
    a_r7_busy_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EN_BUSY && cnt != '0 && rp_n)
        |=> (state == EN_BUSY && cnt == $past(cnt) - 1'b1));

    // R8: a program aimed at a locked block is refused without a busy period.
    a_r8_locked_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EN_PROG_SETUP && wr_evt && blk_locked && rp_n)
        |=> (state == EN_IDLE && sr_lock && sr_prog));

    // R9: the program-fail bit survives anything but a clear command.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_prog && rp_n
         && !(state == EN_IDLE && wr_evt && cmd == OPC_CLR_STATUS))
        |=> sr_prog);

    // R10: a low reset pin abandons any sequence and restores array read.
    a_r10_rp_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_n |=> (state == EN_IDLE && rd_mode == RD_ARRAY));

endmodule

// File: rtl/fcc_word_array.sv
// Register array standing in for the flash cells. On fire it ANDs the
// latched data into one word (program) or sets every word of the latched
// block to ones (erase). Assumes WORDS is a multiple of 2**WW.
module fcc_word_array #(
    parameter int AW    = 5,
    parameter int DW    = 8,
    parameter int WW    = 2,
    parameter int WORDS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          fire_erase,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);

    logic [DW-1:0]    mem [WORDS];
    logic [WORDS-1:0] erase_hit;
    logic [WORDS-1:0] prog_hit;

    // Per-word decode of which words the pending operation touches.
    for (genvar w = 0; w < WORDS; w++) begin : g_hit
        localparam logic [AW-1:0] W_IDX = AW'(w);
        assign erase_hit[w] = fire && fire_erase
                              && ((op_addr >> WW) == (W_IDX >> WW));
        assign prog_hit[w]  = fire && !fire_erase && (op_addr == W_IDX);
    end

    // Apply erase or program to the selected words.
    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n || erase_hit[i]) begin
                mem[i] <= '1;
            end else if (prog_hit[i]) begin
                mem[i] <= mem[i] & op_data;
            end
        end
    end

    // Asynchronous read port; addresses past the map read as erased.
    always_comb begin
        rd_word = (int'(rd_addr) < WORDS) ? mem[rd_addr] : '1;
    end

    // R4: a program never turns a 0 bit back into a 1.
    a_r4_prog_clears_only: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !fire_erase)
        |=> ((mem[$past(op_addr)] & ~$past(mem[op_addr])) == '0));

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the flash command controller: write-edge detection, command
// engine, stand-in array and the read-data mux with bus direction control.
// Assumes all strobes are synchronous to clk; reads are combinational.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int            DW        = 8,
    parameter int            BLK_WORDS = 4,
    parameter int            NUM_PARAM = 4,
    parameter int            NUM_MAIN  = 4,
    parameter int            BUSY_CYC  = 8,
    parameter logic [DW-1:0] MFR_CODE  = DW'(8'hA5),
    parameter logic [DW-1:0] DEV_CODE  = DW'(8'h3C),
    parameter int            ADDR_W    = $clog2((NUM_PARAM + NUM_MAIN) * BLK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rp_n,
    input  logic              wp_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     dq_in,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe
);

    localparam int WORDS = (NUM_PARAM + NUM_MAIN) * BLK_WORDS;
    localparam int WW    = $clog2(BLK_WORDS);

    logic              wr_evt;
    rd_mode_e          rd_mode;
    logic [7:0]        status;
    logic              fire;
    logic              fire_erase;
    logic [ADDR_W-1:0] op_addr;
    logic [DW-1:0]     op_data;
    logic [DW-1:0]     rd_word;
    logic [DW-1:0]     rd_val;

    fcc_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .wr_evt (wr_evt)
    );

    fcc_cmd_engine #(
        .AW       (ADDR_W),
        .DW       (DW),
        .WW       (WW),
        .BUSY_CYC (BUSY_CYC)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .rp_n       (rp_n),
        .wp_n       (wp_n),
        .wr_evt     (wr_evt && rp_n),
        .addr       (addr),
        .dq_in      (dq_in),
        .rd_mode    (rd_mode),
        .status     (status),
        .fire       (fire),
        .fire_erase (fire_erase),
        .op_addr    (op_addr),
        .op_data    (op_data)
    );

    fcc_word_array #(
        .AW    (ADDR_W),
        .DW    (DW),
        .WW    (WW),
        .WORDS (WORDS)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .fire_erase (fire_erase),
        .op_addr    (op_addr),
        .op_data    (op_data),
        .rd_addr    (addr),
        .rd_word    (rd_word)
    );

    // Pick the read source from the current mode.
    always_comb begin
        case (rd_mode)
            RD_IDENT:  rd_val = addr[0] ? DEV_CODE : MFR_CODE;
            RD_STATUS: rd_val = DW'(status);
            default:   rd_val = rd_word;
        endcase
    end

    // Drive the bus only during an enabled read outside reset.
    always_comb begin
        dq_oe  = rp_n && !ce_n && !oe_n;
        dq_out = dq_oe ? rd_val : '0;
    end

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
// Scoreboard bench: read tasks queue expected bus values and a monitor
// pops and compares them a little after each falling clock edge.
module flash_cmd_ctrl_tb_top;

    localparam int DW   = 8;
    localparam int AW   = 5;
    localparam int BUSY = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rp_n = 1'b1;
    logic          wp_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int errors = 0;
    int checks = 0;

    logic [DW-1:0] q_data[$];
    logic          q_oe[$];
    string         q_tag[$];
    bit            mon_req = 1'b0;
    int            nbusy;

    always #5 clk = ~clk;

    flash_cmd_ctrl dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rp_n   (rp_n),
        .wp_n   (wp_n),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .addr   (addr),
        .dq_in  (dq_in),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    function automatic void chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    function automatic void report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endfunction

    // Monitor: pop an expected item for each requested read and compare.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mon_req) begin
                mon_req = 1'b0;
                if (q_data.size() > 0) begin
                    logic [DW-1:0] ed;
                    logic          eo;
                    string         et;
                    ed = q_data.pop_front();
                    eo = q_oe.pop_front();
                    et = q_tag.pop_front();
                    chk(dq_oe == eo && dq_out == ed, et,
                        int'({dq_oe, dq_out}), int'({eo, ed}));
                end
            end
        end
    end

    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d,
                          input logic ce_v = 1'b0);
        @(negedge clk);
        ce_n  = ce_v;
        oe_n  = 1'b1;
        we_n  = 1'b0;
        addr  = a;
        dq_in = d;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e_d,
                      input string tag, input logic ce_v = 1'b0,
                      input logic oe_v = 1'b0, input logic e_oe = 1'b1);
        @(negedge clk);
        ce_n = ce_v;
        oe_n = oe_v;
        addr = a;
        q_data.push_back(e_d);
        q_oe.push_back(e_oe);
        q_tag.push_back(tag);
        mon_req = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
        oe_n = 1'b1;
    endtask

    // Count clocks with the ready bit low, starting right after a write.
    task automatic poll_busy(output int n);
        ce_n = 1'b0;
        oe_n = 1'b0;
        n = 0;
        #1;
        while (!dq_out[7] && n < 100) begin
            n++;
            @(negedge clk);
            #1;
        end
        ce_n = 1'b1;
        oe_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state, R1 bus direction
        rd(5, 8'hFF, "R2 array reads erased after reset");
        rd(5, 8'h00, "R1 released with ce_n high", 1'b1, 1'b0, 1'b0);
        rd(5, 8'h00, "R1 released with oe_n high", 1'b0, 1'b1, 1'b0);
        bus_wr(0, 8'h70);
        rd(0, 8'h80, "R2 status after reset");

        // R3 identifier and array modes
        bus_wr(0, 8'h90);
        rd(0, 8'hA5, "R3 maker code");
        rd(1, 8'h3C, "R3 device code");
        bus_wr(0, 8'hFF);
        rd(1, 8'hFF, "R3 back to array read");

        // R4 and R7: program into unlockable block 2
        bus_wr(9, 8'h40);
        bus_wr(9, 8'h5A);
        poll_busy(nbusy);
        chk(nbusy == BUSY, "R7 program busy length", nbusy, BUSY);
        rd(9, 8'h80, "R7 status mode after program");
        bus_wr(0, 8'hFF);
        rd(9, 8'h5A, "R4 programmed word");
        bus_wr(9, 8'h40);
        bus_wr(9, 8'h0F);
        poll_busy(nbusy);
        bus_wr(0, 8'hFF);
        rd(9, 8'h0A, "R4 program ANDs old value");
        bus_wr(9, 8'h90, 1'b1);
        rd(9, 8'h0A, "R4 write with ce_n high ignored");

        // R8: locked parameter block refuses program
        wp_n = 1'b0;
        bus_wr(2, 8'h40);
        bus_wr(2, 8'h00);
        rd(2, 8'h92, "R8 locked program status");
        bus_wr(0, 8'hFF);
        rd(2, 8'hFF, "R8 locked word unchanged");

        // R9 sticky bits across a good program; R8 block 3 not lockable
        bus_wr(12, 8'h40);
        bus_wr(12, 8'h33);
        poll_busy(nbusy);
        rd(12, 8'h92, "R9 error bits survive success");
        bus_wr(0, 8'hFF);
        rd(12, 8'h33, "R8 unlockable block programmed");
        bus_wr(0, 8'h50);
        bus_wr(0, 8'h70);
        rd(0, 8'h80, "R9 cleared by 0x50");

        // R8: locked erase
        bus_wr(4, 8'h20);
        bus_wr(4, 8'hD0);
        rd(4, 8'hA2, "R8 locked erase status");
        bus_wr(0, 8'h50);

        // R8 with protection off, R5 erase
        wp_n = 1'b1;
        bus_wr(2, 8'h40);
        bus_wr(2, 8'h3C);
        poll_busy(nbusy);
        bus_wr(0, 8'hFF);
        rd(2, 8'h3C, "R8 lockable block open with wp_n high");
        bus_wr(1, 8'h20);
        bus_wr(1, 8'hD0);
        poll_busy(nbusy);
        chk(nbusy == BUSY, "R7 erase busy length", nbusy, BUSY);
        bus_wr(0, 8'hFF);
        rd(2, 8'hFF, "R5 block 0 erased");
        rd(12, 8'h33, "R5 other block untouched");
        bus_wr(14, 8'h20);
        bus_wr(14, 8'hD0);
        poll_busy(nbusy);
        bus_wr(0, 8'hFF);
        rd(12, 8'hFF, "R5 block 3 erased");
        rd(9, 8'h0A, "R5 neighbour block kept");

        // R6 bad erase confirm
        bus_wr(0, 8'h20);
        bus_wr(0, 8'h55);
        rd(0, 8'hB0, "R6 bad confirm status");
        bus_wr(0, 8'hFF);
        rd(9, 8'h0A, "R6 array unchanged");

        // R7 writes during busy ignored
        bus_wr(10, 8'h40);
        bus_wr(10, 8'h11);
        bus_wr(0, 8'hFF);
        poll_busy(nbusy);
        rd(0, 8'hB0, "R7 command during busy ignored");
        bus_wr(0, 8'hFF);
        rd(10, 8'h11, "R4 second word programmed");

        // R10 reset pin abort
        bus_wr(11, 8'h40);
        bus_wr(11, 8'h00);
        repeat (2) @(negedge clk);
        rp_n = 1'b0;
        rd(11, 8'h00, "R10 bus released in reset", 1'b0, 1'b0, 1'b0);
        bus_wr(0, 8'h90);
        @(negedge clk);
        rp_n = 1'b1;
        rd(11, 8'hFF, "R10 aborted program, array mode");
        bus_wr(0, 8'h70);
        rd(0, 8'h80, "R10 error bits cleared");

        repeat (3) @(negedge clk);
        report();
        $finish;
    end

endmodule